// File: doc/BRIEF.md
# Atomic Swap Microsequencer

This block turns a single atomic swap request into a fixed two-step sequence of ordinary micro-operations. When the pipeline's writeback stage raises `swapTrap`, it also supplies the effective address, the value already loaded from that address, and the source and destination register numbers. The block copies the address and the loaded value into hidden scratch registers, freezes fetch, and then issues two micro-instructions from a small internal ROM. The first writes the source register to memory at the scratched address. The second moves the scratched load value into the destination register and carries the end flag.

The integer register file lives in the block. It has an architectural bank and a small hidden scratch bank. A normal writeback port and a microcode port can update it in the same cycle, so the final move and an unrelated pipeline writeback never stall each other. A marker bit placed above the architectural register index selects the scratch bank. An abort input cancels a sequence in flight without touching architectural state.

Top module: `swap_ucode_seq`

## Requirements
- R1: During and right after reset, `fetchHold`, `uopValid`, `uopEnd` and `stValid` are 0, `uopInst`, `stAddr` and `stData` are 0, and every architectural and scratch register reads 0.
- R2: When `swapTrap` is high in an idle cycle, from the next cycle `fetchHold` and `uopValid` are high, scratch 0 holds `swapAddr` and scratch 1 holds `swapLoad`. Scratch entries are read with `rdAddr[5]`=1 and the index in the low bits.
- R3: In the first step `uopEnd` is 0. `stValid` is 1 unless `abortTrap` is high, with `stAddr` equal to scratch 0 and `stData` equal to the current value of the source register. Whenever `stValid` is 0, `stAddr` and `stData` are 0.
- R4: The step after an unaborted first step has `uopValid` and `uopEnd` high. At the next edge the destination register takes the scratch 1 value and `fetchHold` falls.
- R5: `uopInst` is laid out as class [31:30], rd [29:24], opcode [23:18], rs1 [17:12], immediate flag [11] and immediate [10:0]. The store word is class 2'b11, rd = source, opcode 6'h04, rs1 6'h20, immediate flag 1, immediate 0. The move word is class 2'b10, rd = destination, opcode 6'h00, rs1 6'h21, immediate flag 1, immediate 0. When idle, `uopInst` is 0.
- R6: `uopCwpRs1` and `uopCwpRd` are 0 in both steps.
- R7: `abortTrap` high in either step returns the block to idle at the next edge. No store is issued in that cycle and the destination register keeps its old value. In an idle cycle `abortTrap` has no effect.
- R8: `wbEn` writes `wbData` into architectural register `wbAddr` at any time. When the final move and a writeback target the same register in one cycle, the move's value lands. `rdData` shows the addressed register combinationally.
- R9: `swapTrap` raised while a sequence is in flight is ignored. The scratch values and the sequence are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swapTrap | input | 1 | Swap request from writeback |
| swapAddr | input | 32 | Effective address of the swap |
| swapLoad | input | 32 | Value loaded from that address |
| swapSrc | input | 5 | Source register number |
| swapDst | input | 5 | Destination register number |
| abortTrap | input | 1 | Cancels an in-flight sequence |
| wbEn | input | 1 | Pipeline writeback enable |
| wbAddr | input | 5 | Pipeline writeback register |
| wbData | input | 32 | Pipeline writeback data |
| rdAddr | input | 6 | Read address, bit 5 selects the scratch bank |
| rdData | output | 32 | Read data |
| fetchHold | output | 1 | Freezes the fetch PC while microcode runs |
| uopValid | output | 1 | A micro-instruction is issued this cycle |
| uopEnd | output | 1 | End flag of the current micro-instruction |
| uopCwpRs1 | output | 1 | Window override for rs1 |
| uopCwpRd | output | 1 | Window override for rd |
| uopInst | output | 32 | Micro-instruction word |
| stValid | output | 1 | Store issued to memory |
| stAddr | output | 32 | Store address |
| stData | output | 32 | Store data |

## Verification
The first directed swap uses distinct source and destination registers, which confirms that the store reads the source and the move writes the destination. Aborts placed in the store step and in the move step show whether cancellation suppresses the store, the register update, or both. Holding `swapTrap` high through a sequence, and landing a writeback on the destination in the move cycle, show whether busy requests are ignored and which write port wins. Long random runs then mix requests, aborts, writebacks and scratch or architectural reads, so back-to-back sequences and overlapping writes are compared against a cycle model.

// File: rtl/swap_ucode_pkg.sv
package swap_ucode_pkg;

  localparam int WORD_W = 32;
  localparam int REGF_W = 6;

  localparam logic [1:0] CLS_MEM = 2'b11;
  localparam logic [1:0] CLS_ALU = 2'b10;
  localparam logic [5:0] OP_STORE = 6'h04;
  localparam logic [5:0] OP_ADD   = 6'h00;
  // Marker bit ORed into a register field to select the hidden scratch bank.
  localparam logic [5:0] SCR_MARK = 6'h20;
  localparam int RD_LSB = 24;

  typedef enum logic [1:0] {
    UPC_IDLE  = 2'd0,
    UPC_STORE = 2'd1,
    UPC_MOVE  = 2'd2
  } upc_e;

  typedef struct packed {
    logic capture;
    logic issue;
    logic issueStore;
    logic commitMove;
    logic rdFromSrc;
  } strobe_t;

  typedef struct packed {
    logic              endFlag;
    logic              cwpRs1;
    logic              cwpRd;
    logic [WORD_W-1:0] inst;
  } uword_t;

  // Two-entry microcode ROM; the rd field is left zero and filled by the datapath.
  function automatic uword_t romWord(input logic moveStep);
    uword_t w;
    w.endFlag = moveStep;
    w.cwpRs1  = 1'b0;
    w.cwpRd   = 1'b0;
    if (moveStep)
      w.inst = {CLS_ALU, 6'd0, OP_ADD, SCR_MARK | 6'd1, 1'b1, 11'd0};
    else
      w.inst = {CLS_MEM, 6'd0, OP_STORE, SCR_MARK, 1'b1, 11'd0};
    return w;
  endfunction

endpackage

// File: rtl/swap_ucode_ctrl.sv
module swap_ucode_ctrl
  import swap_ucode_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    swapTrap,
  input  logic    abortTrap,
  output strobe_t stb,
  output uword_t  word
);

  upc_e upc;
  upc_e upcNext;

  always_ff @(posedge clk) begin
    if (!rstN) upc <= UPC_IDLE;
    else       upc <= upcNext;
  end

  always_comb begin
    upcNext = upc;
    unique case (upc)
      UPC_IDLE:  if (swapTrap) upcNext = UPC_STORE;
      UPC_STORE: upcNext = abortTrap ? UPC_IDLE : UPC_MOVE;
      UPC_MOVE:  upcNext = UPC_IDLE;
      default:   upcNext = UPC_IDLE;
    endcase
  end

  always_comb begin
    stb            = '0;
    stb.capture    = (upc == UPC_IDLE) && swapTrap;
    stb.issue      = (upc != UPC_IDLE);
    stb.issueStore = (upc == UPC_STORE) && !abortTrap;
    stb.commitMove = (upc == UPC_MOVE) && !abortTrap;
    stb.rdFromSrc  = (upc == UPC_STORE);
  end

  always_comb begin
    if (upc == UPC_IDLE) word = '0;
    else                 word = romWord(upc == UPC_MOVE);
  end

endmodule

// File: rtl/swap_ucode_dp.sv
module swap_ucode_dp
  import swap_ucode_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NARCH = 32,
  parameter int NSCR  = 4,
  localparam int AAW = $clog2(NARCH),
  localparam int SAW = $clog2(NSCR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  uword_t            word,
  input  logic [XLEN-1:0]   swapAddr,
  input  logic [XLEN-1:0]   swapLoad,
  input  logic [AAW-1:0]    swapSrc,
  input  logic [AAW-1:0]    swapDst,
  input  logic              wbEn,
  input  logic [AAW-1:0]    wbAddr,
  input  logic [XLEN-1:0]   wbData,
  input  logic [AAW:0]      rdAddr,
  output logic [XLEN-1:0]   rdData,
  output logic [WORD_W-1:0] uopInst,
  output logic              stValid,
  output logic [XLEN-1:0]   stAddr,
  output logic [XLEN-1:0]   stData
);

  logic [XLEN-1:0] archReg [NARCH];
  logic [XLEN-1:0] scrReg  [NSCR];
  logic [AAW-1:0]  srcQ;
  logic [AAW-1:0]  dstQ;

  // Scratch bank: entry 0 takes the address, entry 1 the loaded value.
  for (genvar i = 0; i < NSCR; i++) begin : g_scr
    if (i < 2) begin : g_live
      always_ff @(posedge clk) begin
        if (!rstN)            scrReg[i] <= '0;
        else if (stb.capture) scrReg[i] <= (i == 0) ? swapAddr : swapLoad;
      end
    end else begin : g_spare
      always_ff @(posedge clk) scrReg[i] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ <= '0;
      dstQ <= '0;
    end else if (stb.capture) begin
      srcQ <= swapSrc;
      dstQ <= swapDst;
    end
  end

  // Two write ports: pipeline writeback, then microcode move (later wins).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NARCH; k++) archReg[k] <= '0;
    end else begin
      if (wbEn)           archReg[wbAddr] <= wbData;
      if (stb.commitMove) archReg[dstQ]   <= scrReg[1];
    end
  end

  always_comb begin
    if (rdAddr[AAW]) rdData = scrReg[rdAddr[SAW-1:0]];
    else             rdData = archReg[rdAddr[AAW-1:0]];
  end

  logic [REGF_W-1:0] regField;
  always_comb begin
    regField = REGF_W'(stb.rdFromSrc ? srcQ : dstQ);
    uopInst  = stb.issue ? (word.inst | (WORD_W'(regField) << RD_LSB)) : '0;
  end

  always_comb begin
    stValid = stb.issueStore;
    stAddr  = stb.issueStore ? scrReg[0]     : '0;
    stData  = stb.issueStore ? archReg[srcQ] : '0;
  end

endmodule

// File: rtl/swap_ucode_seq.sv
module swap_ucode_seq
  import swap_ucode_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NARCH = 32,
  parameter int NSCR  = 4,
  localparam int AAW = $clog2(NARCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swapTrap,
  input  logic [XLEN-1:0]   swapAddr,
  input  logic [XLEN-1:0]   swapLoad,
  input  logic [AAW-1:0]    swapSrc,
  input  logic [AAW-1:0]    swapDst,
  input  logic              abortTrap,
  input  logic              wbEn,
  input  logic [AAW-1:0]    wbAddr,
  input  logic [XLEN-1:0]   wbData,
  input  logic [AAW:0]      rdAddr,
  output logic [XLEN-1:0]   rdData,
  output logic              fetchHold,
  output logic              uopValid,
  output logic              uopEnd,
  output logic              uopCwpRs1,
  output logic              uopCwpRd,
  output logic [WORD_W-1:0] uopInst,
  output logic              stValid,
  output logic [XLEN-1:0]   stAddr,
  output logic [XLEN-1:0]   stData
);

  strobe_t stb;
  uword_t  word;

  swap_ucode_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .swapTrap(swapTrap), .abortTrap(abortTrap),
    .stb(stb), .word(word)
  );

  swap_ucode_dp #(.XLEN(XLEN), .NARCH(NARCH), .NSCR(NSCR)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .word(word),
    .swapAddr(swapAddr), .swapLoad(swapLoad), .swapSrc(swapSrc), .swapDst(swapDst),
    .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData),
    .rdAddr(rdAddr), .rdData(rdData), .uopInst(uopInst),
    .stValid(stValid), .stAddr(stAddr), .stData(stData)
  );

  assign fetchHold = stb.issue;
  assign uopValid  = stb.issue;
  assign uopEnd    = word.endFlag;
  assign uopCwpRs1 = word.cwpRs1;
  assign uopCwpRd  = word.cwpRd;

endmodule

// File: rtl/swap_ucode_chk.sv
module swap_ucode_chk (
  input logic clk,
  input logic rstN,
  input logic swapTrap,
  input logic abortTrap,
  input logic fetchHold,
  input logic uopValid,
  input logic uopEnd,
  input logic stValid
);

  // R2: an idle request starts the sequence at its first step
  a_r2_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchHold && swapTrap) |=> (fetchHold && uopValid && !uopEnd));

  // R3: a store is only issued in an unaborted first step
  a_r3_store_slot: assert property (@(posedge clk) disable iff (!rstN)
    stValid |-> (uopValid && !uopEnd && !abortTrap));

  // R4: an unaborted first step is followed by the ending step
  a_r4_end_follows: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopEnd && !abortTrap) |=> (uopValid && uopEnd));

  // R4: fetch resumes after the micro-op carrying the end flag
  a_r4_release: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopEnd) |=> !fetchHold);

  // R7: abort cancels the sequence
  a_r7_abort: assert property (@(posedge clk) disable iff (!rstN)
    (fetchHold && abortTrap) |=> !fetchHold);

  // R9: a request during the last step does not extend the sequence
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (uopEnd && swapTrap) |=> !uopValid);

endmodule

bind swap_ucode_seq swap_ucode_chk uChk (
  .clk(clk), .rstN(rstN), .swapTrap(swapTrap), .abortTrap(abortTrap),
  .fetchHold(fetchHold), .uopValid(uopValid), .uopEnd(uopEnd), .stValid(stValid)
);

// File: tb/sim_swap_ucode_seq.sv
module sim_swap_ucode_seq;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, swapTrap, abortTrap, wbEn;
  logic [31:0] swapAddr, swapLoad, wbData;
  logic [4:0]  swapSrc, swapDst, wbAddr;
  logic [5:0]  rdAddr;
  logic [31:0] rdData, uopInst, stAddr, stData;
  logic        fetchHold, uopValid, uopEnd, uopCwpRs1, uopCwpRd, stValid;

  swap_ucode_seq u0 (
    .clk(clk), .rstN(rstN), .swapTrap(swapTrap), .swapAddr(swapAddr), .swapLoad(swapLoad),
    .swapSrc(swapSrc), .swapDst(swapDst), .abortTrap(abortTrap), .wbEn(wbEn),
    .wbAddr(wbAddr), .wbData(wbData), .rdAddr(rdAddr), .rdData(rdData),
    .fetchHold(fetchHold), .uopValid(uopValid), .uopEnd(uopEnd), .uopCwpRs1(uopCwpRs1),
    .uopCwpRd(uopCwpRd), .uopInst(uopInst), .stValid(stValid), .stAddr(stAddr), .stData(stData)
  );

  int nCmp = 0;
  int nBad = 0;

  // Reference model state
  logic [31:0] mArch [32];
  logic [31:0] mScr  [4];
  int          mSt;
  logic [4:0]  mSrc, mDst;

  function automatic logic [31:0] storeWord(input logic [4:0] r);
    return {2'b11, {1'b0, r}, 6'h04, 6'h20, 1'b1, 11'd0};
  endfunction

  function automatic logic [31:0] moveWord(input logic [4:0] r);
    return {2'b10, {1'b0, r}, 6'h00, 6'h21, 1'b1, 11'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    logic        eStv;
    logic [31:0] eInst, eRd;
    eStv  = (mSt == 1) && !abortTrap;
    eInst = (mSt == 1) ? storeWord(mSrc) : (mSt == 2) ? moveWord(mDst) : 32'd0;
    eRd   = rdAddr[5] ? mScr[rdAddr[1:0]] : mArch[rdAddr[4:0]];
    chk("R2 fetchHold", 32'(fetchHold), 32'(mSt != 0));
    chk("R2 uopValid", 32'(uopValid), 32'(mSt != 0));
    chk("R4 uopEnd", 32'(uopEnd), 32'(mSt == 2));
    chk("R5 uopInst", uopInst, eInst);
    chk("R6 cwp", {30'd0, uopCwpRs1, uopCwpRd}, 32'd0);
    chk("R3 stValid", 32'(stValid), 32'(eStv));
    chk("R3 stAddr", stAddr, eStv ? mScr[0] : 32'd0);
    chk("R3 stData", stData, eStv ? mArch[mSrc] : 32'd0);
    chk("R8 rdData", rdData, eRd);
  endtask

  task automatic modelEdge();
    if (!rstN) begin
      for (int k = 0; k < 32; k++) mArch[k] = '0;
      for (int k = 0; k < 4; k++) mScr[k] = '0;
      mSt = 0; mSrc = '0; mDst = '0;
    end else begin
      if (wbEn) mArch[wbAddr] = wbData;
      if (mSt == 2 && !abortTrap) mArch[mDst] = mScr[1];
      case (mSt)
        0: if (swapTrap) begin
             mScr[0] = swapAddr; mScr[1] = swapLoad;
             mSrc = swapSrc; mDst = swapDst; mSt = 1;
           end
        1: mSt = abortTrap ? 0 : 2;
        default: mSt = 0;
      endcase
    end
  endtask

  // Called at a negedge with inputs already set.
  task automatic step();
    #2;
    compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic quiet();
    swapTrap = 0; abortTrap = 0; wbEn = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rstN = 0; quiet();
    swapAddr = '0; swapLoad = '0; swapSrc = '0; swapDst = '0;
    wbAddr = '0; wbData = '0; rdAddr = '0;
    for (int k = 0; k < 32; k++) mArch[k] = '0;
    for (int k = 0; k < 4; k++) mScr[k] = '0;
    mSt = 0; mSrc = '0; mDst = '0;
    @(negedge clk);
    step(); step();
    // R1: reset state
    rdAddr = 6'h20; #1 chk("R1 scratch0", rdData, 32'd0);
    rdAddr = 6'h05; #1 chk("R1 arch5", rdData, 32'd0);
    chk("R1 fetchHold", 32'(fetchHold), 32'd0);
    rstN = 1;
    step();

    // Directed: preload r3, swap r3 -> r7
    wbEn = 1; wbAddr = 5'd3; wbData = 32'hAAAA_0003; step();
    quiet();
    swapTrap = 1; swapAddr = 32'h0000_1000; swapLoad = 32'h0000_0055;
    swapSrc = 5'd3; swapDst = 5'd7; step();
    swapTrap = 0; rdAddr = 6'h21; step();   // store step
    rdAddr = 6'h07; step();                 // move step
    #1 chk("R4 dst loaded", rdData, 32'h0000_0055);
    chk("R4 hold released", 32'(fetchHold), 32'd0);
    step();

    // R7: abort in store step
    swapTrap = 1; swapLoad = 32'h1111_2222; swapDst = 5'd9; step();
    swapTrap = 0; abortTrap = 1; #1 chk("R7 no store", 32'(stValid), 32'd0);
    step();
    abortTrap = 0; rdAddr = 6'h09;
    #1 chk("R7 idle after abort", 32'(fetchHold), 32'd0);
    chk("R7 dst kept", rdData, 32'd0);
    step();

    // R7: abort in move step
    swapTrap = 1; swapLoad = 32'h3333_4444; swapDst = 5'd10; step();
    swapTrap = 0; step();
    abortTrap = 1; step();
    abortTrap = 0; rdAddr = 6'h0A;
    #1 chk("R7 move aborted", rdData, 32'd0);
    step();

    // R9: request held high through a sequence
    swapTrap = 1; swapAddr = 32'h0000_2000; swapLoad = 32'h0000_0777; swapDst = 5'd11; step();
    swapAddr = 32'hDEAD_0000; swapLoad = 32'hBEEF_0000; rdAddr = 6'h20; step();
    #1 chk("R9 scratch0 kept", rdData, 32'h0000_2000);
    step();
    #1 chk("R9 idle after end", 32'(fetchHold), 32'd0);
    swapTrap = 0;
    step(); step(); step();

    // R8: writeback collides with move on destination
    swapTrap = 1; swapLoad = 32'h0000_0ABC; swapDst = 5'd12; step();
    swapTrap = 0; step();
    wbEn = 1; wbAddr = 5'd12; wbData = 32'h0000_0FFF; step();
    wbEn = 0; rdAddr = 6'h0C;
    #1 chk("R8 move wins", rdData, 32'h0000_0ABC);
    step();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      swapTrap  = ($urandom % 4) == 0;
      abortTrap = ($urandom % 8) == 0;
      wbEn      = ($urandom % 2) == 0;
      wbAddr    = 5'($urandom);
      wbData    = $urandom;
      swapAddr  = $urandom;
      swapLoad  = $urandom;
      swapSrc   = 5'($urandom);
      swapDst   = 5'($urandom);
      rdAddr    = 6'($urandom);
      step();
    end

    summary();
    $finish;
  end

endmodule